// File: doc/BRIEF.md
# Reduced-Precision Floating-Point Adder

This block adds or subtracts two numbers held in a narrow binary floating-point format. The exponent and fraction widths are parameters. Each operand is a sign bit, a biased exponent and a fraction with an implicit leading one. The unit compares magnitudes and swaps the operands if needed. It aligns the smaller significand while keeping guard, round and sticky bits, then adds or subtracts the significands. It normalizes with a leading-zero count, rounds in one of two modes and encodes infinity and NaN.

Results are captured in a single output register. A result appears one cycle after the operands are presented with `inValid` high, and the outputs hold when `inValid` is low. The exception handling is deliberately simple. Denormal operands count as zero, tiny results flush to zero, overflow saturates to infinity, and two flags report an invalid operation and an overflow. This keeps the area and power small for signal-processing datapaths that do not need full single precision.

Top module: `lite_fp_adder`

## Requirements
- R1: `outValid` is high exactly in the cycle after a clock edge that sampled `inValid` high. `result`, `flagInvalid` and `flagOverflow` change only at an edge that samples `inValid` high, and otherwise hold their values.
- R2: Operand and result layout: bit W-1 is the sign, the next EXP_W bits are the exponent biased by 2^(EXP_W-1)-1 (15 by default), and the low FRAC_W bits are the fraction. With `rndMode`=1, an effective addition of two normal operands returns the sum rounded to nearest, with ties going to an even fraction. A rounding carry out of the fraction raises the exponent by one.
- R3: With `rndMode`=0, the result is truncated toward zero, and the discarded alignment bits never increment the fraction.
- R4: `subOp`=1 negates operand B. When the effective signs differ, the magnitudes are subtracted and the result takes the sign of the larger magnitude. The result is normalized by shifting left and lowering the exponent. An exact cancellation gives +0.
- R5: If either operand is NaN (exponent all ones, fraction nonzero), the result is the canonical NaN: sign 0, exponent all ones, only the fraction MSB set. `flagInvalid` stays 0.
- R6: Two infinities (exponent all ones, fraction zero) with opposite effective signs give the canonical NaN with `flagInvalid`=1.
- R7: An infinity combined with a finite operand, or with an infinity of the same effective sign, returns that infinity with both flags 0.
- R8: If the rounded exponent reaches all ones, the result is infinity carrying the result sign, with `flagOverflow`=1 and `flagInvalid`=0.
- R9: An operand with a zero exponent is treated as zero, whatever its fraction, and the other operand is returned with its effective sign. If both operands are zero, the result is zero, and it is negative only when both effective signs are negative.
- R10: A nonzero result whose exponent after normalization and rounding would be below 1 flushes to zero carrying the result sign.
- R11: While `rstN` is low, `outValid`, `result`, `flagInvalid` and `flagOverflow` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands valid; capture a new result |
| opA | input | 1+EXP_W+FRAC_W | First operand |
| opB | input | 1+EXP_W+FRAC_W | Second operand |
| subOp | input | 1 | 1 computes opA - opB, 0 computes opA + opB |
| rndMode | input | 1 | 0 truncate toward zero, 1 round to nearest even |
| outValid | output | 1 | Result registers hold a fresh result |
| result | output | 1+EXP_W+FRAC_W | Sum or difference in the operand format |
| flagInvalid | output | 1 | Infinity minus infinity occurred |
| flagOverflow | output | 1 | Result saturated to infinity |

## Verification
The bench builds the unit with its default widths: 5 exponent bits and 8 fraction bits. In this format every exponent code, from the smallest normal through the largest finite value to infinity and NaN, takes one short hand-computed operand. Because the fraction is only 8 bits, an exact half-way tie can be set up with an odd or an even last fraction bit using one small addend. An alignment distance larger than the extended significand is easy to reach, and so are a rounding carry that ripples into the exponent and a cancellation deep enough to reach the flush-to-zero boundary.

// File: rtl/lite_fp_pkg.sv
package lite_fp_pkg;

  typedef enum logic {
    RND_TRUNC   = 1'b0,
    RND_NEAREST = 1'b1
  } rnd_mode_e;

  typedef struct packed {
    logic capture;
    logic roundNearest;
  } fp_strobe_t;

endpackage

// File: rtl/lite_fp_ctrl.sv
module lite_fp_ctrl
  import lite_fp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       rndMode,
  output fp_strobe_t strb,
  output logic       outValid
);

  always_comb begin
    strb.capture      = inValid;
    strb.roundNearest = (rnd_mode_e'(rndMode) == RND_NEAREST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/lite_fp_dp.sv
module lite_fp_dp
  import lite_fp_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fp_strobe_t                strb,
  input  logic [EXP_W+FRAC_W:0]     opA,
  input  logic [EXP_W+FRAC_W:0]     opB,
  input  logic                      subOp,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic                      flagInvalid,
  output logic                      flagOverflow
);

  localparam int W       = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int EXT_W   = SIG_W + 3;
  localparam int LZ_W    = $clog2(EXT_W + 1);
  localparam int EXPX_W  = EXP_W + LZ_W + 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam logic signed [EXPX_W-1:0] EXP_TOP  = EXPX_W'(EXP_MAX);
  localparam logic signed [EXPX_W-1:0] EXP_ZERO = '0;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [LZ_W-1:0] lzCount(input logic [EXT_W-1:0] v);
    lzCount = LZ_W'(EXT_W);
    for (int i = 0; i < EXT_W; i++)
      if (v[i]) lzCount = LZ_W'(EXT_W - 1 - i);
  endfunction

  // operand fields, B carries its effective sign
  logic              sA, sB;
  logic [EXP_W-1:0]  eA, eB;
  logic [FRAC_W-1:0] fA, fB;
  logic nanA, nanB, infA, infB, zeroA, zeroB;

  assign sA = opA[W-1];
  assign eA = opA[W-2:FRAC_W];
  assign fA = opA[FRAC_W-1:0];
  assign sB = opB[W-1] ^ subOp;
  assign eB = opB[W-2:FRAC_W];
  assign fB = opB[FRAC_W-1:0];

  assign nanA  = (&eA) && (|fA);
  assign nanB  = (&eB) && (|fB);
  assign infA  = (&eA) && !(|fA);
  assign infB  = (&eB) && !(|fB);
  assign zeroA = !(|eA);
  assign zeroB = !(|eB);

  // magnitude ordering
  logic              aBig, bigS, smlS, effSub;
  logic [EXP_W-1:0]  bigE, smlE;
  logic [FRAC_W-1:0] bigF, smlF;

  always_comb begin
    aBig = {eA, fA} >= {eB, fB};
    bigS = aBig ? sA : sB;
    bigE = aBig ? eA : eB;
    bigF = aBig ? fA : fB;
    smlS = aBig ? sB : sA;
    smlE = aBig ? eB : eA;
    smlF = aBig ? fB : fA;
    effSub = bigS ^ smlS;
  end

  // alignment with guard, round and sticky
  logic [31:0]      diffWide;
  logic [EXT_W-1:0] bigExt, smlExt, smlAl, keepMask;

  always_comb begin
    diffWide = 32'(bigE - smlE);
    bigExt   = {1'b1, bigF, 3'b000};
    smlExt   = {1'b1, smlF, 3'b000};
    keepMask = '1;
    if (diffWide >= 32'(EXT_W)) begin
      smlAl    = '0;
      smlAl[0] = 1'b1;
    end else begin
      keepMask = {EXT_W{1'b1}} << diffWide;
      smlAl    = smlExt >> diffWide;
      smlAl[0] = smlAl[0] | (|(smlExt & ~keepMask));
    end
  end

  // add / subtract and normalize
  logic [EXT_W:0]              sumExt;
  logic [EXT_W-1:0]            normSig;
  logic [LZ_W-1:0]             lz;
  logic signed [EXPX_W-1:0]    normExp;

  always_comb begin
    if (effSub) sumExt = {1'b0, bigExt} - {1'b0, smlAl};
    else        sumExt = {1'b0, bigExt} + {1'b0, smlAl};
    lz = lzCount(sumExt[EXT_W-1:0]);
    if (!effSub && sumExt[EXT_W]) begin
      normSig = sumExt[EXT_W:1] | {{(EXT_W-1){1'b0}}, sumExt[0]};
      normExp = $signed(EXPX_W'(bigE)) + $signed(EXPX_W'(1));
    end else begin
      normSig = sumExt[EXT_W-1:0] << lz;
      normExp = $signed(EXPX_W'(bigE)) - $signed(EXPX_W'(lz));
    end
  end

  // rounding
  logic                     sumZero, roundUp;
  logic [FRAC_W:0]          fracInc;
  logic signed [EXPX_W-1:0] finalExp;
  logic [FRAC_W-1:0]        finalFrac;

  always_comb begin
    sumZero = !normSig[EXT_W-1];
    roundUp = strb.roundNearest && normSig[2] && (normSig[1] || normSig[0] || normSig[3]);
    fracInc = {1'b0, normSig[EXT_W-2:3]} + (FRAC_W+1)'(roundUp);
    if (fracInc[FRAC_W]) finalExp = normExp + $signed(EXPX_W'(1));
    else                 finalExp = normExp;
    finalFrac = fracInc[FRAC_W-1:0];
  end

  // special-value selection
  logic [W-1:0] resNext;
  logic         invNext, ovfNext;

  always_comb begin
    invNext = 1'b0;
    ovfNext = 1'b0;
    if (nanA || nanB) begin
      resNext = QNAN;
    end else if (infA && infB && (sA != sB)) begin
      resNext = QNAN;
      invNext = 1'b1;
    end else if (infA) begin
      resNext = {sA, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (infB) begin
      resNext = {sB, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (zeroA && zeroB) begin
      resNext = {sA & sB, {(W-1){1'b0}}};
    end else if (zeroA) begin
      resNext = {sB, eB, fB};
    end else if (zeroB) begin
      resNext = opA;
    end else if (sumZero) begin
      resNext = '0;
    end else if (finalExp >= EXP_TOP) begin
      resNext = {bigS, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovfNext = 1'b1;
    end else if (finalExp <= EXP_ZERO) begin
      resNext = {bigS, {(W-1){1'b0}}};
    end else begin
      resNext = {bigS, finalExp[EXP_W-1:0], finalFrac};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result       <= '0;
      flagInvalid  <= 1'b0;
      flagOverflow <= 1'b0;
    end else if (strb.capture) begin
      result       <= resNext;
      flagInvalid  <= invNext;
      flagOverflow <= ovfNext;
    end
  end

endmodule

// File: rtl/lite_fp_adder.sv
module lite_fp_adder
  import lite_fp_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic                  subOp,
  input  logic                  rndMode,
  output logic                  outValid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  flagInvalid,
  output logic                  flagOverflow
);

  localparam int W = 1 + EXP_W + FRAC_W;

  fp_strobe_t strb;

  lite_fp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .rndMode  (rndMode),
    .strb     (strb),
    .outValid (outValid)
  );

  lite_fp_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .opA          (opA),
    .opB          (opB),
    .subOp        (subOp),
    .result       (result),
    .flagInvalid  (flagInvalid),
    .flagOverflow (flagOverflow)
  );

endmodule

// File: rtl/lite_fp_adder_chk.sv
module lite_fp_adder_chk #(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic [EXP_W+FRAC_W-1:0] opAMag,
  input logic                    outValid,
  input logic [EXP_W+FRAC_W:0]   result,
  input logic                    flagInvalid,
  input logic                    flagOverflow
);

  logic aIsNaN, resIsNaN, resIsInf;

  assign aIsNaN   = (&opAMag[EXP_W+FRAC_W-1:FRAC_W]) && (|opAMag[FRAC_W-1:0]);
  assign resIsNaN = (&result[EXP_W+FRAC_W-1:FRAC_W]) && (|result[FRAC_W-1:0]);
  assign resIsInf = (&result[EXP_W+FRAC_W-1:FRAC_W]) && !(|result[FRAC_W-1:0]);

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R1
  AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R1
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result) && $stable(flagInvalid) && $stable(flagOverflow));  // R1
  AST_NAN_PROPAGATE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && aIsNaN) |=> (resIsNaN && !flagInvalid));  // R5
  AST_INVALID_NAN: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalid |-> resIsNaN);  // R6
  AST_OVERFLOW_INF: assert property (@(posedge clk) disable iff (!rstN)
    flagOverflow |-> (resIsInf && !flagInvalid));  // R8

endmodule

bind lite_fp_adder lite_fp_adder_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .opAMag       (opA[W-2:0]),
  .outValid     (outValid),
  .result       (result),
  .flagInvalid  (flagInvalid),
  .flagOverflow (flagOverflow)
);

// File: tb/lite_fp_adder_bench.sv
`timescale 1ns/1ps
module lite_fp_adder_bench;

  localparam int EXP_W  = 5;
  localparam int FRAC_W = 8;
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int NV     = 35;

  // {req, opA, opB, subOp, rndMode, expected result, expected invalid, expected overflow}
  localparam logic [53:0] VEC [NV] = '{
    {8'd2,  14'h0F00, 14'h0F00, 1'b0, 1'b1, 14'h1000, 1'b0, 1'b0}, // R2 1+1
    {8'd2,  14'h0F00, 14'h1000, 1'b0, 1'b1, 14'h1080, 1'b0, 1'b0}, // R2 1+2
    {8'd2,  14'h0F01, 14'h0600, 1'b0, 1'b1, 14'h0F02, 1'b0, 1'b0}, // R2 tie, odd -> up
    {8'd3,  14'h0F01, 14'h0600, 1'b0, 1'b0, 14'h0F01, 1'b0, 1'b0}, // R3 truncate
    {8'd2,  14'h0F00, 14'h0680, 1'b0, 1'b1, 14'h0F01, 1'b0, 1'b0}, // R2 above half
    {8'd3,  14'h0F00, 14'h0680, 1'b0, 1'b0, 14'h0F00, 1'b0, 1'b0}, // R3
    {8'd2,  14'h0FFF, 14'h0600, 1'b0, 1'b1, 14'h1000, 1'b0, 1'b0}, // R2 carry into exponent
    {8'd3,  14'h0FFF, 14'h0600, 1'b0, 1'b0, 14'h0FFF, 1'b0, 1'b0}, // R3
    {8'd2,  14'h0F00, 14'h0100, 1'b0, 1'b1, 14'h0F00, 1'b0, 1'b0}, // R2 far shift, sticky only
    {8'd4,  14'h1080, 14'h0F00, 1'b1, 1'b1, 14'h1000, 1'b0, 1'b0}, // R4 3-1
    {8'd4,  14'h1000, 14'h1080, 1'b1, 1'b1, 14'h2F00, 1'b0, 1'b0}, // R4 2-3
    {8'd4,  14'h0F01, 14'h0F00, 1'b1, 1'b1, 14'h0700, 1'b0, 1'b0}, // R4 deep normalize
    {8'd4,  14'h0F00, 14'h0F00, 1'b1, 1'b1, 14'h0000, 1'b0, 1'b0}, // R4 exact cancel
    {8'd4,  14'h2F00, 14'h0F00, 1'b0, 1'b1, 14'h0000, 1'b0, 1'b0}, // R4 -1+1 -> +0
    {8'd8,  14'h1EFF, 14'h1EFF, 1'b0, 1'b1, 14'h1F00, 1'b0, 1'b1}, // R8
    {8'd8,  14'h3EFF, 14'h3EFF, 1'b0, 1'b0, 14'h3F00, 1'b0, 1'b1}, // R8 negative
    {8'd8,  14'h1EFF, 14'h3EFF, 1'b1, 1'b1, 14'h1F00, 1'b0, 1'b1}, // R8 via subtract
    {8'd7,  14'h1F00, 14'h0F00, 1'b0, 1'b1, 14'h1F00, 1'b0, 1'b0}, // R7
    {8'd7,  14'h3F00, 14'h1000, 1'b0, 1'b1, 14'h3F00, 1'b0, 1'b0}, // R7
    {8'd7,  14'h0F00, 14'h1F00, 1'b1, 1'b1, 14'h3F00, 1'b0, 1'b0}, // R7 1-inf
    {8'd6,  14'h1F00, 14'h1F00, 1'b1, 1'b1, 14'h1F80, 1'b1, 1'b0}, // R6 inf-inf
    {8'd6,  14'h1F00, 14'h3F00, 1'b0, 1'b0, 14'h1F80, 1'b1, 1'b0}, // R6 inf+(-inf)
    {8'd7,  14'h1F00, 14'h1F00, 1'b0, 1'b1, 14'h1F00, 1'b0, 1'b0}, // R7 same sign
    {8'd5,  14'h1F01, 14'h0F00, 1'b0, 1'b1, 14'h1F80, 1'b0, 1'b0}, // R5
    {8'd5,  14'h0F00, 14'h3F7F, 1'b0, 1'b1, 14'h1F80, 1'b0, 1'b0}, // R5
    {8'd5,  14'h1F01, 14'h1F00, 1'b1, 1'b1, 14'h1F80, 1'b0, 1'b0}, // R5 NaN beats inf
    {8'd9,  14'h0001, 14'h0F00, 1'b0, 1'b1, 14'h0F00, 1'b0, 1'b0}, // R9 denormal flushed
    {8'd9,  14'h00AB, 14'h0001, 1'b0, 1'b1, 14'h0000, 1'b0, 1'b0}, // R9
    {8'd9,  14'h20AB, 14'h20AB, 1'b0, 1'b1, 14'h2000, 1'b0, 1'b0}, // R9 both negative
    {8'd9,  14'h2000, 14'h2000, 1'b0, 1'b1, 14'h2000, 1'b0, 1'b0}, // R9
    {8'd9,  14'h0000, 14'h2000, 1'b0, 1'b1, 14'h0000, 1'b0, 1'b0}, // R9 mixed zeros
    {8'd9,  14'h0000, 14'h2F00, 1'b1, 1'b1, 14'h0F00, 1'b0, 1'b0}, // R9 0-(-1)
    {8'd10, 14'h0101, 14'h0100, 1'b1, 1'b1, 14'h0000, 1'b0, 1'b0}, // R10
    {8'd10, 14'h0100, 14'h0101, 1'b1, 1'b1, 14'h2000, 1'b0, 1'b0}, // R10 signed
    {8'd10, 14'h0200, 14'h0101, 1'b1, 1'b0, 14'h0000, 1'b0, 1'b0}  // R10
  };

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [W-1:0] opA, opB;
  logic         subOp, rndMode;
  logic         outValid;
  logic [W-1:0] result;
  logic         flagInvalid, flagOverflow;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  lite_fp_adder #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lite_fp_adder (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .opA          (opA),
    .opB          (opB),
    .subOp        (subOp),
    .rndMode      (rndMode),
    .outValid     (outValid),
    .result       (result),
    .flagInvalid  (flagInvalid),
    .flagOverflow (flagOverflow)
  );

  task automatic check(input bit ok, input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; opA = '0; opB = '0; subOp = 1'b0; rndMode = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(outValid == 1'b0 && result == '0 && !flagInvalid && !flagOverflow, 11,
          {outValid, flagInvalid, result}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, 1, {15'd0, outValid}, 16'h0);  // R1 idle after reset

    // back-to-back vectors, result one cycle after capture (R1..R10)
    for (int i = 0; i < NV; i++) begin
      logic [53:0] v;
      v = VEC[i];
      opA = v[45:32]; opB = v[31:18]; subOp = v[17]; rndMode = v[16]; inValid = 1'b1;
      @(negedge clk);
      check(outValid && result == v[15:2] && flagInvalid == v[1] && flagOverflow == v[0],
            int'(v[53:46]), {outValid, flagInvalid, flagOverflow, result[12:0]},
            {1'b1, v[1], v[0], v[14:2]});
    end

    // R1 hold: new operands without inValid must not disturb outputs
    inValid = 1'b0; opA = 14'h0F00; opB = 14'h0F00; subOp = 1'b0; rndMode = 1'b1;
    @(negedge clk);
    check(!outValid && result == 14'h0000 && !flagInvalid && !flagOverflow, 1,
          {outValid, 1'b0, result}, 16'h0000);
    @(negedge clk);
    check(!outValid && result == 14'h0000, 1, {outValid, 1'b0, result}, 16'h0000);

    // R1 flags hold after an overflow result while idle
    opA = 14'h1EFF; opB = 14'h1EFF; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; opA = 14'h0F00; opB = 14'h0F00;
    @(negedge clk);
    check(!outValid && result == 14'h1F00 && flagOverflow, 1,
          {outValid, flagOverflow, result}, {2'b01, 14'h1F00});

    // R11 reset clears a live result
    rstN = 1'b0;
    @(negedge clk);
    check(!outValid && result == '0 && !flagOverflow, 11,
          {outValid, flagOverflow, result}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule